// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns a parallel byte into one asynchronous character on a single serial output. While no character is in flight the output sits at mark (logic 1). A character goes out as one low start bit, the data bits with the least significant bit first, an optional parity bit, and then one or two high stop bits. The duration of every bit comes from a 16-bit divisor. The divisor counts system clock cycles, so the baud rate can be changed at run time. With a system clock of up to about 3.2 MHz, this spans the 50 to 9600 baud range.

A host presents a byte, the framing options and the divisor, then pulses a load strobe while busy is low. The block takes a copy of everything on that edge and drives the frame on its own. Busy stays high until the final stop bit has had its full time on the line. In addition to the usual parity bit appended after eight data bits, a seven-bit character mode puts the parity value into bit 7 of the byte itself.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `tx_busy` is 0.
- R2: On the clock edge that accepts a load, `tx_line` goes to 0 for the start bit. It stays at 0 for exactly one bit time.
- R3: After the start bit, eight data bits are sent, bit 0 first and bit 7 last.
- R4: A frame ends with one stop bit at 1 when `cfg_two_stop` is 0, and with two stop bits at 1 when it is 1.
- R5: When `cfg_parity_en` is 1 and `cfg_seven_par` is 0, one parity bit follows bit 7. With `cfg_parity_odd`=0 the eight data bits plus the parity bit hold an even number of ones. With `cfg_parity_odd`=1 they hold an odd number.
- R6: When `cfg_seven_par` is 1, the bit sent in the bit 7 slot is a parity value computed over data bits 6..0. It is even parity when `cfg_parity_odd`=0 and odd parity when it is 1. No extra parity bit is sent, and `cfg_parity_en` has no effect in this mode.
- R7: Every bit lasts `bit_div` clock cycles. A divisor of 0 behaves as 1.
- R8: `tx_busy` rises on the accepting edge and stays high for exactly N×D cycles. N = 1 + 8 + (1 if an appended parity bit is sent) + (1 or 2 stop bits), and D is the bit time from R7. After that, `tx_busy` falls with `tx_line` at 1.
- R9: A load strobe while `tx_busy` is 1 is ignored. Data, configuration and divisor are captured only on acceptance, so changing them during a frame leaves that frame unchanged.
- R10: A load presented in the first cycle in which `tx_busy` is low is accepted. The next frame then starts with no idle bit time between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Load strobe, accepted when busy is low |
| cfg_parity_en | input | 1 | Append a parity bit (8-bit mode) |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_seven_par | input | 1 | Seven-bit character with parity in bit 7 |
| bit_div | input | 16 | Clock cycles per bit |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
Random bytes are sent under every mix of parity enable, parity sense, stop count and seven-bit mode. This separates a wrong bit order from a wrong parity sense, and it separates a missing stop bit from a frame that is one bit too long. Divisors of 0, 1, small values and one larger value show whether timing is counted per bit or per frame, and whether the zero case is handled. Some frames get random load pulses and random changes to data, configuration and divisor while they are in flight. Gaps of zero to two cycles between frames exercise the back-to-back start.

// File: rtl/async_frame_tx_pkg.sv
package async_frame_tx_pkg;
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
    logic seven;
  } frame_cfg_t;
endpackage

// File: rtl/aftx_baud_timer.sv
module aftx_baud_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] lim_q, lim_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lim_en, cnt_en;

  // divisor 0 is treated as 1; store period minus one
  always_comb begin
    lim_en = restart;
    lim_d  = (div_in == '0) ? '0 : div_in - 1'b1;
  end

  assign tick = run && (cnt_q == lim_q);

  always_comb begin
    cnt_en = restart || run;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim_q));

  // R7
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/aftx_framer.sv
module aftx_framer
  import async_frame_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  frame_cfg_t         cfg,
  output logic [FRAME_W-1:0] word,
  output logic [CNT_W-1:0]   nbits
);
  logic [DATA_W-1:0] data_eff;
  logic              low_par;
  logic              full_par;
  logic              append_par;

  assign low_par    = (^data[DATA_W-2:0]) ^ cfg.par_odd;
  assign full_par   = (^data) ^ cfg.par_odd;
  assign append_par = cfg.par_en && !cfg.seven;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_data
      if (i == DATA_W - 1) begin : g_top
        assign data_eff[i] = cfg.seven ? low_par : data[i];
      end else begin : g_low
        assign data_eff[i] = data[i];
      end
    end
  endgenerate

  // bits after the start bit; unused upper slots stay at mark
  always_comb begin
    word = '1;
    word[DATA_W-1:0] = data_eff;
    if (append_par) word[DATA_W] = full_par;
  end

  always_comb begin
    nbits = CNT_W'(DATA_W + 1);
    if (append_par)   nbits = nbits + 1'b1;
    if (cfg.two_stop) nbits = nbits + 1'b1;
  end
endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic [CNT_W-1:0]   frame_bits,
  output logic               accept,
  output logic               line,
  output logic               busy
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               line_q, line_d;
  logic               busy_q, busy_d;
  logic               step;

  assign accept = load && !busy_q;
  assign step   = busy_q && tick;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    line_d = line_q;
    busy_d = busy_q;
    if (accept) begin
      sh_d   = frame_word;
      left_d = frame_bits;
      line_d = 1'b0;
      busy_d = 1'b1;
    end else if (step) begin
      if (left_q == '0) begin
        line_d = 1'b1;
        busy_d = 1'b0;
      end else begin
        line_d = sh_q[0];
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        left_d = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      line_q <= 1'b1;
      busy_q <= 1'b0;
    end else if (accept || step) begin
      sh_q   <= sh_d;
      left_q <= left_d;
      line_q <= line_d;
      busy_q <= busy_d;
    end
  end

  assign line = line_q;
  assign busy = busy_q;

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line_q);

  // R4
  last_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(line_q));

  // R9
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load && !tick) |=> ($stable(sh_q) && $stable(left_q) && $stable(line_q)));
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import async_frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_seven_par,
  input  logic [DIV_W-1:0]  bit_div,
  output logic              tx_line,
  output logic              tx_busy
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  frame_cfg_t         cfg;
  logic [FRAME_W-1:0] word;
  logic [CNT_W-1:0]   nbits;
  logic               accept;
  logic               tick;
  logic               busy;
  logic               line;

  assign cfg = '{par_en: cfg_parity_en, par_odd: cfg_parity_odd,
                 two_stop: cfg_two_stop, seven: cfg_seven_par};

  aftx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data  (tx_data),
    .cfg   (cfg),
    .word  (word),
    .nbits (nbits)
  );

  aftx_baud_timer #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .div_in  (bit_div),
    .tick    (tick)
  );

  aftx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (tx_load),
    .tick       (tick),
    .frame_word (word),
    .frame_bits (nbits),
    .accept     (accept),
    .line       (line),
    .busy       (busy)
  );

  assign tx_line = line;
  assign tx_busy = busy;

  // R8
  busy_rise_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_busy) |=> tx_busy);
endmodule

// File: tb/async_frame_tx_tb_top.sv
module async_frame_tx_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  tx_data;
  logic        tx_load;
  logic        cfg_parity_en, cfg_parity_odd, cfg_two_stop, cfg_seven_par;
  logic [15:0] bit_div;
  logic        tx_line, tx_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  async_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_seven_par(cfg_seven_par),
    .bit_div(bit_div), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // whole line pattern including start bit, index 0 sent first
  function automatic logic [11:0] model_frame(input logic [7:0] d, input bit pe,
      input bit po, input bit ts, input bit sv, output int n);
    logic [11:0] f;
    logic [7:0]  dd;
    int          p;
    f  = '1;
    dd = d;
    if (sv) dd[7] = (^d[6:0]) ^ po;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = dd[i];
    p = 9;
    if (pe && !sv) begin
      f[9] = (^d) ^ po;
      p = 10;
    end
    n = p + (ts ? 2 : 1);
    return f;
  endfunction

  function automatic string tag_of(input int idx, input bit pe, input bit sv);
    if (idx == 0) return "R2";
    if (idx == 8 && sv) return "R6";
    if (idx <= 8) return "R3";
    if (idx == 9 && pe && !sv) return "R5";
    return "R4";
  endfunction

  task automatic send(input logic [7:0] d, input bit pe, input bit po, input bit ts,
      input bit sv, input logic [15:0] dv, input bit inject, input int gap);
    int          n, dcyc, tot;
    logic [11:0] f;
    bit          intact;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(tx_line === 1'b1, "R1", tx_line, 1);
      check(tx_busy === 1'b0, "R1", tx_busy, 0);
    end
    f    = model_frame(d, pe, po, ts, sv, n);
    dcyc = (dv == 0) ? 1 : int'(dv);
    tot  = n * dcyc;
    tx_data = d; cfg_parity_en = pe; cfg_parity_odd = po;
    cfg_two_stop = ts; cfg_seven_par = sv; bit_div = dv;
    tx_load = 1'b1;
    intact = 1;
    for (int k = 0; k <= tot; k++) begin
      @(negedge clk);
      if (k < tot) begin
        if (tx_line !== f[k / dcyc]) intact = 0;
        check(tx_line === f[k / dcyc],
              (k % dcyc == dcyc - 1 && k / dcyc == 0) ? "R7" : tag_of(k / dcyc, pe, sv),
              tx_line, f[k / dcyc]);
        check(tx_busy === 1'b1, (k == 0 && gap == 0) ? "R10" : "R8", tx_busy, 1);
        if (inject) begin
          tx_load = ($urandom % 3) == 0;
          tx_data = 8'($urandom);
          {cfg_parity_en, cfg_parity_odd, cfg_two_stop, cfg_seven_par} = 4'($urandom);
          bit_div = 16'($urandom % 9);
        end else begin
          tx_load = 1'b0;
        end
      end else begin
        check(tx_busy === 1'b0, "R8", tx_busy, 0);
        check(tx_line === 1'b1, "R8", tx_line, 1);
        tx_load = 1'b0;
      end
    end
    if (inject) check(intact, "R9", intact, 1);
  endtask

  initial begin
    int c;
    c = 0;
    while (!done) begin
      @(posedge clk);
      c++;
      if (c > 150000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", c);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1DE5EED));
    rst_n = 1'b0; tx_load = 1'b0; tx_data = '0; bit_div = 16'd1;
    {cfg_parity_en, cfg_parity_odd, cfg_two_stop, cfg_seven_par} = '0;
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1, "R1", tx_line, 1);
    check(tx_busy === 1'b0, "R1", tx_busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_line === 1'b1, "R1", tx_line, 1);
    check(tx_busy === 1'b0, "R1", tx_busy, 0);

    // directed corners
    send(8'hA5, 0, 0, 0, 0, 16'd1, 0, 1);   // R3 plain 8N1, fastest
    send(8'h01, 0, 0, 1, 0, 16'd3, 0, 0);   // R4 two stops, R10 back-to-back
    send(8'h80, 1, 0, 0, 0, 16'd2, 0, 0);   // R5 even parity
    send(8'h80, 1, 1, 0, 0, 16'd2, 0, 2);   // R5 odd parity
    send(8'h7F, 0, 0, 1, 1, 16'd2, 0, 1);   // R6 seven-bit even
    send(8'h03, 1, 1, 0, 1, 16'd4, 0, 0);   // R6 seven-bit odd, par_en no effect
    send(8'hFF, 1, 0, 1, 0, 16'd0, 0, 1);   // R7 divisor zero
    send(8'h3C, 1, 1, 1, 0, 16'd20, 1, 0);  // R9 disturbance, long bit

    for (int i = 0; i < 180; i++) begin
      send(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom % 7), 1'(($urandom % 2) == 0), int'($urandom % 3));
    end
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1, "R1", tx_line, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule